// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word of each downstream port of a USB root hub. For each port it tracks whether a device is attached, whether software has enabled the port, and whether the port is selectively suspended. It also keeps sticky change flags for attach/detach and for loss of enable. A line-state model of the port PHY feeds it a connect level and a one-cycle K-state pulse. In return the block gives a request to drive K-state (resume) on the port and a one-cycle request to end that resume with a single-ended zero.

Software picks a port with a select input. It reads the port's word combinationally and writes it with a one-cycle write strobe. The number of ports is a parameter, and each port has its own copy of the logic. Events on one port reach only that port's word. Software can set the suspend bit only while the port is enabled, or to keep it set while it is already set.

Top module: `rhp_top`

## Requirements
- R1: Bit 0 (connect) equals the port's connect line as sampled at the previous clock edge. Software writes to bit 0 have no effect.
- R2: Bit 1 (connect change) is set whenever the connect flag changes, and it stays set through further changes. A write with bit 1 = 1 clears it and a write with bit 1 = 0 leaves it. A hardware set in the same cycle wins over the clear.
- R3: A detach, meaning the line falls while bit 0 is 1, clears bit 0 and bit 2 (enable) and sets bit 1 and bit 3 (enable change).
- R4: Bit 3 is cleared by writing 1 to it, and writing 0 leaves it unchanged.
- R5: Writing bit 2 = 1 enables the port only when bit 0 is 1. Writing bit 2 = 0 disables it.
- R6: A K-state pulse on a port whose bit 2 and bit 12 (suspend) are both 1 sets bit 6 (resume). While bit 6 is 1 the port's drive-K output is 1.
- R7: A K-state pulse on a port that is disabled, or enabled but not suspended, changes nothing.
- R8: Writing bit 6 = 1 starts a resume only on a suspended port, or holds a resume that is already active. Writing bit 6 = 0 clears it.
- R9: The port's SE0 output pulses for one cycle when bit 12 falls with bit 6 = 0, after a resume that ended either in that same write or in an earlier write. Clearing bit 12 while bit 6 is still 1 gives no pulse, now or later.
- R10: A write to the selected port, and line events on one port, leave every other port's word and outputs unchanged.
- R11: During reset every word and output is 0. In the first cycle after reset, bit 0 takes the line value, and a line that is high counts as a connect change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_conn_i | input | NPORT | Connect level per port from the PHY model |
| kstate_i | input | NPORT | One-cycle K-state (resume) pulse per port |
| sel_i | input | SEL_W | Port selected for read and write |
| wr_i | input | 1 | Write strobe for the selected port |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Word of the selected port (combinational) |
| drive_k_o | output | NPORT | Per-port request to drive K-state |
| se0_o | output | NPORT | Per-port one-cycle request to end a resume with SE0 |

## Verification
Every result in this block is due one clock edge after its stimulus. Line levels, K pulses and writes are all captured at the next rising edge. The word, drive-K and SE0 all change right at that edge, because the read path adds no register after the state. The bench applies each stimulus between edges, waits for one rising edge and samples a quarter period later. Because SE0 is a registered pulse, the bench checks it at exactly that sample and checks again one cycle later that it has dropped.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int REG_W  = 16;
  localparam int B_CONN = 0;
  localparam int B_CSC  = 1;
  localparam int B_EN   = 2;
  localparam int B_PEC  = 3;
  localparam int B_RES  = 6;
  localparam int B_SUSP = 12;

  typedef struct packed {
    logic conn;
    logic csc;
    logic en;
    logic pec;
    logic res;
    logic susp;
  } pstate_t;

  // sticky flag: a hardware set wins over a write-one clear
  function automatic logic sticky_w1c(logic old, logic hw_set, logic wr, logic wbit);
    return hw_set | (old & ~(wr & wbit));
  endfunction

  function automatic logic resume_next(logic old, logic susp_old, logic k_hit,
                                       logic wr, logic wbit);
    logic kept;
    kept = wr ? (wbit & (susp_old | old)) : old;
    return k_hit | kept;
  endfunction

  // resume ended with correct ordering: suspend falls while resume is low
  function automatic logic end_ok(logic susp_old, logic susp_new, logic res_old,
                                  logic res_new, logic pend);
    return susp_old & ~susp_new & ~res_new & (res_old | pend);
  endfunction

  function automatic logic [REG_W-1:0] pack_word(pstate_t s);
    logic [REG_W-1:0] w;
    w         = '0;
    w[B_CONN] = s.conn;
    w[B_CSC]  = s.csc;
    w[B_EN]   = s.en;
    w[B_PEC]  = s.pec;
    w[B_RES]  = s.res;
    w[B_SUSP] = s.susp;
    return w;
  endfunction
endpackage

// File: rtl/rhp_port.sv
module rhp_port
  import rhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             k_i,
  input  logic             wr_i,
  input  logic             w_csc,
  input  logic             w_en,
  input  logic             w_pec,
  input  logic             w_res,
  input  logic             w_susp,
  output logic [REG_W-1:0] word_o,
  output logic             drive_k_o,
  output logic             se0_o
);
  pstate_t st_q, st_n;
  logic    pend_q, pend_n;
  logic    se0_q;

  // named events, also used by the bound checker
  logic att_ev, det_ev, kres_ev, term_ev;

  assign att_ev  = ~st_q.conn & line_i;
  assign det_ev  = st_q.conn & ~line_i;
  assign kres_ev = k_i & st_q.en & st_q.susp;

  always_comb begin
    st_n      = st_q;
    st_n.conn = line_i;
    st_n.csc  = sticky_w1c(st_q.csc, att_ev | det_ev, wr_i, w_csc);
    st_n.pec  = sticky_w1c(st_q.pec, det_ev, wr_i, w_pec);
    if (det_ev)    st_n.en = 1'b0;
    else if (wr_i) st_n.en = w_en & st_q.conn;
    if (wr_i)      st_n.susp = w_susp & (st_q.en | st_q.susp);
    st_n.res  = resume_next(st_q.res, st_q.susp, kres_ev, wr_i, w_res);
  end

  assign term_ev = end_ok(st_q.susp, st_n.susp, st_q.res, st_n.res, pend_q);
  assign pend_n  = st_n.susp & ((st_q.res & ~st_n.res) | pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      pend_q <= 1'b0;
      se0_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      se0_q  <= term_ev;
    end
  end

  assign word_o    = pack_word(st_q);
  assign drive_k_o = st_q.res;
  assign se0_o     = se0_q;
endmodule

// File: rtl/rhp_rdmux.sv
module rhp_rdmux
  import rhp_pkg::*;
#(
  parameter int N     = 2,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][REG_W-1:0] words_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [REG_W-1:0]        rd_o
);
  always_comb begin
    rd_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_i == SEL_W'(i)) rd_o = words_i[i];
  end
endmodule

// File: rtl/rhp_top.sv
module rhp_top
  import rhp_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] line_conn_i,
  input  logic [NPORT-1:0] kstate_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output logic [NPORT-1:0] drive_k_o,
  output logic [NPORT-1:0] se0_o
);
  logic [NPORT-1:0][REG_W-1:0] words;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[15:13], wdata_i[11:7], wdata_i[5:4], wdata_i[0]};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic wr_me;
    assign wr_me = wr_i && (sel_i == SEL_W'(g));
    rhp_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_conn_i[g]),
      .k_i      (kstate_i[g]),
      .wr_i     (wr_me),
      .w_csc    (wdata_i[B_CSC]),
      .w_en     (wdata_i[B_EN]),
      .w_pec    (wdata_i[B_PEC]),
      .w_res    (wdata_i[B_RES]),
      .w_susp   (wdata_i[B_SUSP]),
      .word_o   (words[g]),
      .drive_k_o(drive_k_o[g]),
      .se0_o    (se0_o[g])
    );
  end

  rhp_rdmux #(.N(NPORT), .SEL_W(SEL_W)) u_mux (
    .words_i(words),
    .sel_i  (sel_i),
    .rd_o   (rdata_o)
  );
endmodule

// File: rtl/rhp_port_chk.sv
module rhp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic line_i,
  input logic k_i,
  input logic wr_i,
  input logic w_csc,
  input logic conn,
  input logic csc,
  input logic en,
  input logic pec,
  input logic res,
  input logic susp,
  input logic det_ev,
  input logic drive_k_o,
  input logic se0_o
);
  a_r1_conn_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> conn == $past(line_i));

  a_r2_csc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    csc && !(wr_i && w_csc) |=> csc);

  a_r3_detach: assert property (@(posedge clk) disable iff (!rst_n)
    det_ev |=> !conn && !en && csc && pec);

  a_r5_en_needs_dev: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(conn));

  a_r6_k_taken: assert property (@(posedge clk) disable iff (!rst_n)
    k_i && en && susp |=> res && drive_k_o);

  a_r7_k_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    k_i && !(en && susp) && !wr_i |=> res == $past(res));

  a_r9_se0_order: assert property (@(posedge clk) disable iff (!rst_n)
    se0_o |-> !susp && !res && $past(susp));
endmodule

bind rhp_port rhp_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_i   (line_i),
  .k_i      (k_i),
  .wr_i     (wr_i),
  .w_csc    (w_csc),
  .conn     (st_q.conn),
  .csc      (st_q.csc),
  .en       (st_q.en),
  .pec      (st_q.pec),
  .res      (st_q.res),
  .susp     (st_q.susp),
  .det_ev   (det_ev),
  .drive_k_o(drive_k_o),
  .se0_o    (se0_o)
);

// File: tb/sim_rhp_top.sv
module sim_rhp_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  line;
    logic [1:0]  k;
    logic        wr;
    logic        sel;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    logic [1:0]  exp_k;
    logic [1:0]  exp_se0;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0003, 2'b00, 2'b00}, //  0 R1 R2 attach
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0002, 16'h0001, 2'b00, 2'b00}, //  1 R2 clear
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0005, 2'b00, 2'b00}, //  2 R5 enable
    '{2'b01, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h0005, 2'b00, 2'b00}, //  3 R7 K not suspended
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1004, 16'h1005, 2'b00, 2'b00}, //  4 suspend
    '{2'b01, 2'b00, 1'b0, 1'b1, 16'h0000, 16'h0000, 2'b00, 2'b00}, //  5 R10 other port idle
    '{2'b01, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h1045, 2'b01, 2'b00}, //  6 R6 K taken
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1004, 16'h1005, 2'b00, 2'b00}, //  7 R9 resume off first
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0005, 2'b00, 2'b01}, //  8 R9 then suspend off
    '{2'b01, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0005, 2'b00, 2'b00}, //  9 R9 pulse one cycle
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1004, 16'h1005, 2'b00, 2'b00}, // 10 suspend
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1044, 16'h1045, 2'b01, 2'b00}, // 11 R8 forced resume
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0005, 2'b00, 2'b01}, // 12 R9 both in one write
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1004, 16'h1005, 2'b00, 2'b00}, // 13 suspend
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1044, 16'h1045, 2'b01, 2'b00}, // 14 R8 forced resume
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0044, 16'h0045, 2'b01, 2'b00}, // 15 R9 wrong order
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0005, 2'b00, 2'b00}, // 16 R9 no pulse
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h0044, 16'h0005, 2'b00, 2'b00}, // 17 R8 not suspended
    '{2'b01, 2'b00, 1'b1, 1'b0, 16'h1004, 16'h1005, 2'b00, 2'b00}, // 18 suspend
    '{2'b00, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h100A, 2'b00, 2'b00}, // 19 R3 detach
    '{2'b00, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h100A, 2'b00, 2'b00}, // 20 R7 K on disabled
    '{2'b00, 2'b00, 1'b1, 1'b0, 16'h000A, 16'h0000, 2'b00, 2'b00}, // 21 R4 R2 clear both
    '{2'b00, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0000, 2'b00, 2'b00}, // 22 R5 no device
    '{2'b10, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b00, 2'b00}, // 23 R10 neighbour attach
    '{2'b10, 2'b00, 1'b0, 1'b1, 16'h0000, 16'h0003, 2'b00, 2'b00}, // 24 R10 port 1 word
    '{2'b11, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0003, 2'b00, 2'b00}, // 25 R1 attach again
    '{2'b10, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h000A, 2'b00, 2'b00}, // 26 R2 R3 sticky detach
    '{2'b11, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h000B, 2'b00, 2'b00}, // 27 R2 still set
    '{2'b11, 2'b00, 1'b1, 1'b0, 16'h0000, 16'h000B, 2'b00, 2'b00}, // 28 R1 R2 R4 zero write
    '{2'b10, 2'b00, 1'b1, 1'b0, 16'h0002, 16'h000A, 2'b00, 2'b00}, // 29 R2 set beats clear
    '{2'b10, 2'b00, 1'b0, 1'b1, 16'h0000, 16'h0003, 2'b00, 2'b00}  // 30 R10 port 1 untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  line_conn = '0;
  logic [1:0]  kstate = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  drive_k;
  logic [1:0]  se0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rhp_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_conn_i(line_conn),
    .kstate_i   (kstate),
    .sel_i      (sel),
    .wr_i       (wr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .drive_k_o  (drive_k),
    .se0_o      (se0)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R11 reset state
    check("R11 reset word", rdata, 16'h0000);
    check("R11 reset drive_k", {14'd0, drive_k}, 16'h0000);
    check("R11 reset se0", {14'd0, se0}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      line_conn = VEC[i].line;
      kstate    = VEC[i].k;
      wr        = VEC[i].wr;
      sel       = VEC[i].sel;
      wdata     = VEC[i].wd;
      @(posedge clk);
      #(CLK_P/4);
      check($sformatf("vec %0d word", i), rdata, VEC[i].exp_rd);
      check($sformatf("vec %0d drive_k", i), {14'd0, drive_k}, {14'd0, VEC[i].exp_k});
      check($sformatf("vec %0d se0", i), {14'd0, se0}, {14'd0, VEC[i].exp_se0});
    end

    // R11: reset with both lines high, then connect loads on first edge
    wr = 1'b0; kstate = '0; line_conn = 2'b11; sel = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
    check("R11 word held in reset", rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    check("R11 port0 first cycle", rdata, 16'h0003);
    sel = 1'b1;
    #1;
    check("R11 port1 first cycle", rdata, 16'h0003);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule